// File: doc/BRIEF.md
# Scannable Dual-Table Logic Cell Tile

The block is a tile of programmable logic cells. Each cell holds two 3-input lookup tables. The top address bit of each table comes from a 2-input NAND of two cell pins, so a table can realise a subset of 4-input functions. A capture selector decides what the cell's single flip-flop loads on each clock edge: table A, table B, their exclusive-OR, or its own value. A per-cell configuration bit drives the cell's output pin from either the flip-flop or the combinational selector result.

Every flip-flop has a multiplexer-based scan front end and runs on the ordinary system clock. The cells of the tile form one scan string in index order. With the default parameters the tile is a 16 x 16 array, which gives a 256-stage string. Configuration words (truth tables, capture select, output select) are static inputs held by the surrounding logic.

Top module: `lut_tile`

## Requirements
- R1: Table A of a cell outputs bit tt_a[{~(pin2 & pin3), pin1, pin0}]. Here pin k is bit k of the cell's 5-bit slice cell_in[i*5 +: 5], and tt_a is cfg bits [7:0] of the cell's 19-bit slice cell_cfg[i*19 +: 19].
- R2: Table B outputs tt_b[{~(pin0 & pin1), pin4, pin3}], with tt_b at cfg bits [15:8].
- R3: With scan_en and rst low, the cap field (cfg bits [17:16]) sets what the flip-flop loads at the next edge: 00 loads table A, 01 loads table B, 10 loads A XOR B, and 11 keeps the current value.
- R4: When cfg bit 18 is 1, cell_out[i] shows the flip-flop. When it is 0, cell_out[i] shows the combinational selector result, and that result is the flip-flop value when cap is 11.
- R5: When rst is high at a clock edge, every flip-flop clears to 0. Reset wins over scan_en.
- R6: When scan_en is high and rst is low, each flip-flop loads its scan predecessor and ignores the pins and cap. Cell 0's predecessor is scan_in.
- R7: scan_out is the flip-flop of the highest-index cell. A bit presented on scan_in appears on scan_out after exactly ROWS*COLS shifting edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used for both functional and scan operation |
| rst | input | 1 | Synchronous active-high reset of all flip-flops |
| scan_en | input | 1 | Selects scan shifting instead of functional capture |
| scan_in | input | 1 | Serial input to cell 0 |
| cell_in | input | ROWS*COLS*5 | Five logic pins per cell, cell i at [i*5 +: 5] |
| cell_cfg | input | ROWS*COLS*19 | Static configuration per cell, cell i at [i*19 +: 19] |
| cell_out | output | ROWS*COLS | Output pin of each cell |
| scan_out | output | 1 | Serial output from the last cell |

## Verification
The bench sweeps all 32 pin patterns against random truth tables. A NAND wired to the wrong pins or an address bit in the wrong place would then give wrong bits only for some patterns. Capture-select decoding is exercised through hold mode: a hold that reloaded table data would drift once inputs change. Scan is checked for exact latency over the full string, since an extra or missing stage would shift the pattern by one edge. Reset is asserted while scan_en is high, so a design that let shifting take priority would leave stale bits in the string.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int LUT_IN    = 3;
    localparam int TT_W      = 1 << LUT_IN;
    localparam int CELL_PINS = 5;

    typedef enum logic [1:0] {
        CAP_A    = 2'b00,
        CAP_B    = 2'b01,
        CAP_XOR  = 2'b10,
        CAP_HOLD = 2'b11
    } cap_sel_e;

    typedef struct packed {
        logic              reg_out;
        cap_sel_e          cap;
        logic [TT_W-1:0]   tt_b;
        logic [TT_W-1:0]   tt_a;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic nand_x;
        logic nand_y;
        logic hi;
        logic lo;
    } lut_pins_t;

    // Address of a table: the NAND result is the most significant bit.
    function automatic logic [LUT_IN-1:0] table_addr(lut_pins_t p);
        return {~(p.nand_x & p.nand_y), p.hi, p.lo};
    endfunction

endpackage

// File: rtl/lut3_nand.sv
module lut3_nand
    import lut_cell_pkg::*;
(
    input  logic [TT_W-1:0] truth,
    input  lut_pins_t       pins,
    output logic            y
);
    logic [LUT_IN-1:0] addr;

    always_comb begin
        addr = table_addr(pins);
        y    = truth[addr];
    end
endmodule

// File: rtl/cap_select.sv
module cap_select
    import lut_cell_pkg::*;
(
    input  cap_sel_e cap,
    input  logic     tab_a,
    input  logic     tab_b,
    input  logic     cur_q,
    output logic     sel_y
);
    always_comb begin
        unique case (cap)
            CAP_A:    sel_y = tab_a;
            CAP_B:    sel_y = tab_b;
            CAP_XOR:  sel_y = tab_a ^ tab_b;
            default:  sel_y = cur_q;
        endcase
    end
endmodule

// File: rtl/scan_dff.sv
module scan_dff (
    input  logic clk,
    input  logic rst,
    input  logic se,
    input  logic si,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (se)
            q <= si;
        else
            q <= d;
    end

    p_reset_clear_r5: assert property (@(posedge clk) rst |=> (q == 1'b0))
        else $error("reset did not clear flop");

    p_scan_load_r6: assert property (@(posedge clk) disable iff (rst)
        se |=> (q == $past(si)))
        else $error("scan load mismatch");
endmodule

// File: rtl/logic_cell.sv
module logic_cell
    import lut_cell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 se,
    input  logic                 si,
    input  logic [CELL_PINS-1:0] pin,
    input  cell_cfg_t            cfg,
    output logic                 y,
    output logic                 q
);
    lut_pins_t pins_a, pins_b;
    logic      tab_a, tab_b, sel_y;

    always_comb begin
        pins_a = '{nand_x: pin[2], nand_y: pin[3], hi: pin[1], lo: pin[0]};
        pins_b = '{nand_x: pin[0], nand_y: pin[1], hi: pin[4], lo: pin[3]};
    end

    lut3_nand u_tab_a (.truth(cfg.tt_a), .pins(pins_a), .y(tab_a));
    lut3_nand u_tab_b (.truth(cfg.tt_b), .pins(pins_b), .y(tab_b));

    cap_select u_sel (
        .cap   (cfg.cap),
        .tab_a (tab_a),
        .tab_b (tab_b),
        .cur_q (q),
        .sel_y (sel_y)
    );

    scan_dff u_ff (
        .clk (clk),
        .rst (rst),
        .se  (se),
        .si  (si),
        .d   (sel_y),
        .q   (q)
    );

    assign y = cfg.reg_out ? q : sel_y;

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!se && cfg.cap != CAP_HOLD) |=> (q == $past(sel_y)))
        else $error("functional capture mismatch");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!se && cfg.cap == CAP_HOLD) |=> $stable(q))
        else $error("hold mode changed flop");
endmodule

// File: rtl/lut_tile.sv
module lut_tile
    import lut_cell_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           scan_en,
    input  logic                           scan_in,
    input  logic [ROWS*COLS*CELL_PINS-1:0] cell_in,
    input  logic [ROWS*COLS*CFG_W-1:0]     cell_cfg,
    output logic [ROWS*COLS-1:0]           cell_out,
    output logic                           scan_out
);
    localparam int NCELLS = ROWS * COLS;

    logic [NCELLS:0] chain;

    assign chain[0] = scan_in;

    for (genvar i = 0; i < NCELLS; i++) begin : g_cell
        logic_cell u_cell (
            .clk (clk),
            .rst (rst),
            .se  (scan_en),
            .si  (chain[i]),
            .pin (cell_in[i*CELL_PINS +: CELL_PINS]),
            .cfg (cell_cfg_t'(cell_cfg[i*CFG_W +: CFG_W])),
            .y   (cell_out[i]),
            .q   (chain[i+1])
        );
    end

    assign scan_out = chain[NCELLS];

    p_scan_tail_r7: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (scan_out == $past(chain[NCELLS-1])))
        else $error("scan tail mismatch");
endmodule

// File: tb/lut_tile_test.sv
`timescale 1ns/1ps
module lut_tile_test;
    localparam int N  = 256;
    localparam int NP = 5;
    localparam int CW = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_en = 1'b0;
    logic scan_in = 1'b0;
    logic [N*NP-1:0] cin = '0;
    logic [N*CW-1:0] cfg = '0;
    logic [N-1:0]    cout;
    logic            sout;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [N-1:0] mq;

    always #2 clk = ~clk;

    lut_tile #(.ROWS(16), .COLS(16)) uut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .cell_in(cin), .cell_cfg(cfg), .cell_out(cout), .scan_out(sout)
    );

    function automatic logic tab_a(int i);
        logic [4:0] d = cin[i*NP +: NP];
        logic [7:0] t = cfg[i*CW +: 8];
        int idx = (!(d[2] && d[3]) ? 4 : 0) + (d[1] ? 2 : 0) + (d[0] ? 1 : 0);
        return t[idx];
    endfunction

    function automatic logic tab_b(int i);
        logic [4:0] d = cin[i*NP +: NP];
        logic [7:0] t = cfg[i*CW + 8 +: 8];
        int idx = (!(d[0] && d[1]) ? 4 : 0) + (d[4] ? 2 : 0) + (d[3] ? 1 : 0);
        return t[idx];
    endfunction

    function automatic logic sel_val(int i);
        case (cfg[i*CW + 16 +: 2])
            2'd0: return tab_a(i);
            2'd1: return tab_b(i);
            2'd2: return tab_a(i) ^ tab_b(i);
            default: return mq[i];
        endcase
    endfunction

    // Behavioural reference updated on each rising edge.
    always @(posedge clk) begin
        logic [N-1:0] nq;
        if (rst) nq = '0;
        else if (scan_en) nq = {mq[N-2:0], scan_in};
        else for (int i = 0; i < N; i++) nq[i] = sel_val(i);
        mq = nq;
    end

    task automatic compare(string tag);
        logic [N-1:0] exp;
        for (int i = 0; i < N; i++) exp[i] = cfg[i*CW + 18] ? mq[i] : sel_val(i);
        vectors++;
        if (cout !== exp || sout !== mq[N-1]) begin
            fails++;
            $display("FAIL %s: cell_out=%h expected %h scan_out=%b expected %b",
                     tag, cout, exp, sout, mq[N-1]);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rand_pins();
        for (int w = 0; w < N*NP; w++) cin[w] = 1'($urandom);
    endtask

    // sel_force / ro_force of -1 mean random.
    task automatic rand_cfg(int sel_force, int ro_force);
        for (int i = 0; i < N; i++) begin
            cfg[i*CW +: 16]     = 16'($urandom);
            cfg[i*CW + 16 +: 2] = (sel_force < 0) ? 2'($urandom) : 2'(sel_force);
            cfg[i*CW + 18]      = (ro_force < 0) ? 1'($urandom) : 1'(ro_force);
        end
    endtask

    task automatic all_pins(int v);
        for (int i = 0; i < N; i++) cin[i*NP +: NP] = 5'(v);
    endtask

    initial begin
        logic [2*N-1:0] pat;
        rand_cfg(-1, 1);
        rand_pins();
        rst = 1'b1;
        repeat (3) step("R5 reset state");
        rst = 1'b0;

        // R1/R2: full pin sweep against random tables, combinational output.
        for (int t = 0; t < 4; t++) begin
            rand_cfg(0, 0);
            for (int v = 0; v < 32; v++) begin all_pins(v); step("R1 R4 table A sweep"); end
            rand_cfg(1, 0);
            for (int v = 0; v < 32; v++) begin all_pins(v); step("R2 R4 table B sweep"); end
            rand_cfg(2, 0);
            for (int v = 0; v < 32; v++) begin all_pins(v); step("R3 R4 xor sweep"); end
        end

        // R3/R4: mixed capture, hold and output modes.
        for (int c = 0; c < 800; c++) begin
            if (c % 40 == 0) rand_cfg(-1, -1);
            rand_pins();
            step("R3 R4 capture and hold");
        end

        // R6/R7: shift a known pattern through the whole string.
        for (int w = 0; w < 2*N; w++) pat[w] = 1'($urandom);
        scan_en = 1'b1;
        for (int j = 0; j < 2*N; j++) begin
            scan_in = pat[j];
            rand_pins();
            if (j % 64 == 0) rand_cfg(-1, -1);
            step("R6 scan ignores function");
            if (j + 1 >= N) begin
                vectors++;
                if (sout !== pat[j+1-N]) begin
                    fails++;
                    $display("FAIL R7 latency: scan_out=%b expected %b at edge %0d",
                             sout, pat[j+1-N], j + 1);
                end
            end
        end

        // R5: reset overrides scan.
        rand_cfg(-1, 1);
        scan_in = 1'b1;
        rst = 1'b1;
        step("R5 reset over scan");
        rst = 1'b0;
        scan_en = 1'b0;
        for (int c = 0; c < 100; c++) begin
            rand_pins();
            if (c % 25 == 0) rand_cfg(-1, -1);
            step("R3 R4 after reset");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule